// File: doc/BRIEF.md
# DMA Instruction Stream Packer

This block turns a DMA instruction program held in word-aligned slots into the dense byte stream that the DMA engine fetches. Each instruction begins in a new 32-bit word, and most of the bytes in those words are padding. The block reads the words in order through an asynchronous word-read port. It decides from the lowest byte of each instruction's first word how many words the instruction occupies and which bytes are meaningful. It then sends only those bytes out on a byte stream with valid/ready flow control.

Software or a sequencer gives a word address and pulses `start`. The block runs until it reaches the terminating opcode and then pulses `done`, with the number of emitted bytes on `byte_count`. If it meets an opcode it does not recognise, it stops. It then raises `error` and holds the faulting opcode and the word address where it was found, until the next `start`.

Top module: `dma_code_packer`

## Requirements
- R1: After reset, `out_valid`, `done`, `busy` and `error` are low and `byte_count` is zero.
- R2: Byte k of a word is bits [8k+7:8k]. A word whose byte 0 is 0xBC starts a two-word instruction. The block emits bytes 0 and 1 of that word, then bytes 0, 1, 2, 3 of the next word, and the following instruction starts two words later.
- R3: A word whose byte 0 is 0x20, 0x22, 0x34, 0x38 or 0x3C emits its bytes 0 and 1 only. Bytes 2 and 3 are dropped.
- R4: A word whose byte 0 is 0x04, 0x08 or 0x13 emits its byte 0 only.
- R5: A word whose byte 0 is 0x00 emits a single 0x00 byte and ends the run. `done` is high for exactly the one cycle after that byte is accepted. At that time `byte_count` equals the number of bytes emitted in the run, terminator included, and `busy` is low.
- R6: Any other value of byte 0 in an instruction's first word emits nothing. The block raises `error`, shows that byte on `err_opcode` and the word's address on `err_addr`, and emits no bytes while `error` stays high. `error` stays high until the next `start`.
- R7: While `out_valid` is high and `out_ready` is low, `out_byte` and `rd_addr` hold their values.
- R8: `start` has no effect while `busy` is high. The output stream of the current run is unchanged.
- R9: `start` while idle or faulted begins a run at `start_addr`. On the next cycle `busy` is high, `byte_count` is zero and `error` is low. This holds even when `start` arrives in the same cycle as the `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when not busy |
| start_addr | input | AW | Word address of the first instruction |
| rd_addr | output | AW | Word address being read |
| rd_data | input | 32 | Word at `rd_addr`, same cycle |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready |
| out_byte | output | 8 | Packed byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the terminator byte is accepted |
| byte_count | output | CW | Bytes emitted in the current or last run |
| error | output | 1 | Unknown opcode met |
| err_opcode | output | 8 | Faulting opcode |
| err_addr | output | AW | Word address of the faulting opcode |

## Verification
Two events can fall in the same cycle: the end of a run, marked by the `done` pulse, and the start of the next run. The bench waits for the `done` pulse and drives `start` during that same cycle, so the design sees the start request on the edge that closes the pulse. It then checks three things: the pulse held the final count, the following cycle shows `busy` high with a cleared count, and the second run produces its own complete byte stream. A related overlap, a `start` that arrives while a run is stalled by backpressure, is judged by checking that the emitted stream is still that of the first program.

// File: rtl/pk_pkg.sv
`timescale 1ns/1ps
// pk_pkg: shared widths and the opcode classes used by the packer.
// Assumes little-endian byte numbering within a 32-bit word.
package pk_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_IW = $clog2(LANES);

    typedef enum logic [2:0] {
        CLS_WIDE   = 3'd0,   // head byte pair plus one full extension word
        CLS_PAIR   = 3'd1,   // two kept bytes
        CLS_SINGLE = 3'd2,   // one kept byte
        CLS_STOP   = 3'd3,   // terminator, one zero byte
        CLS_BAD    = 3'd4    // unrecognised
    } op_cls_e;
endpackage

// File: rtl/pk_opdecode.sv
`timescale 1ns/1ps
// pk_opdecode: classifies an instruction's first byte.
// Purely combinational; assumes the byte is stable while it is examined.
module pk_opdecode
    import pk_pkg::*;
(
    input  logic [7:0] opcode,
    output op_cls_e    cls
);
    // map each known opcode value to its class
    always_comb begin
        unique case (opcode)
            8'hBC:                               cls = CLS_WIDE;
            8'h20, 8'h22, 8'h34, 8'h38, 8'h3C:   cls = CLS_PAIR;
            8'h04, 8'h08, 8'h13:                 cls = CLS_SINGLE;
            8'h00:                               cls = CLS_STOP;
            default:                             cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/pk_lane_mux.sv
`timescale 1ns/1ps
// pk_lane_mux: selects one byte lane of a word.
// Lane k is bits [8k+7:8k]; the lane count comes from the package.
module pk_lane_mux
    import pk_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [LANE_IW-1:0] sel,
    output logic [7:0]         lane_byte
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    // pick the addressed lane
    assign lane_byte = lanes[sel];
endmodule

// File: rtl/pk_sequencer.sv
`timescale 1ns/1ps
// pk_sequencer: walks the padded program word by word and counts kept bytes.
// Assumes rd_data reflects rd_addr in the same cycle; the class and the
// selected byte come from neighbouring combinational blocks.
module pk_sequencer
    import pk_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      start_addr,
    input  op_cls_e            cls,
    input  logic [7:0]         opcode,
    input  logic               out_ready,
    output logic [AW-1:0]      rd_addr,
    output logic [LANE_IW-1:0] lane_sel,
    output logic               out_valid,
    output logic               busy,
    output logic               done,
    output logic [CW-1:0]      byte_count,
    output logic               error,
    output logic [7:0]         err_opcode,
    output logic [AW-1:0]      err_addr
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FAULT} seq_state_e;

    localparam logic [LANE_IW-1:0] LAST_FULL = LANE_IW'(LANES - 1);

    seq_state_e          state_q;
    logic [AW-1:0]       addr_q;
    logic [LANE_IW-1:0]  idx_q;
    logic                ext_q;
    logic [CW-1:0]       cnt_q;
    logic                done_q;
    logic                err_q;
    logic [7:0]          err_op_q;
    logic [AW-1:0]       err_addr_q;

    logic [LANE_IW-1:0]  last_idx;
    logic                bad_head;
    logic                fire;
    logic                word_end;

    // index of the last kept byte in the current word
    always_comb begin
        if (ext_q)
            last_idx = LAST_FULL;
        else if (cls == CLS_WIDE || cls == CLS_PAIR)
            last_idx = LANE_IW'(1);
        else
            last_idx = '0;
    end

    // handshake and fault qualifiers
    assign bad_head  = !ext_q && (cls == CLS_BAD);
    assign out_valid = (state_q == S_RUN) && !bad_head;
    assign fire      = out_valid && out_ready;
    assign word_end  = (idx_q == last_idx);

    // run control, address walk, byte counting and fault capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            addr_q     <= '0;
            idx_q      <= '0;
            ext_q      <= 1'b0;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_op_q   <= '0;
            err_addr_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE, S_FAULT: begin
                    if (start) begin
                        state_q <= S_RUN;
                        addr_q  <= start_addr;
                        idx_q   <= '0;
                        ext_q   <= 1'b0;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (bad_head) begin
                        state_q    <= S_FAULT;
                        err_q      <= 1'b1;
                        err_op_q   <= opcode;
                        err_addr_q <= addr_q;
                    end else if (fire) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (word_end) begin
                            idx_q <= '0;
                            if (!ext_q && cls == CLS_STOP) begin
                                state_q <= S_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                addr_q <= addr_q + 1'b1;
                                ext_q  <= !ext_q && (cls == CLS_WIDE);
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rd_addr    = addr_q;
    assign lane_sel   = idx_q;
    assign busy       = (state_q == S_RUN);
    assign done       = done_q;
    assign byte_count = cnt_q;
    assign error      = err_q;
    assign err_opcode = err_op_q;
    assign err_addr   = err_addr_q;
endmodule

// File: rtl/dma_code_packer.sv
`timescale 1ns/1ps
// dma_code_packer: packs a word-slotted DMA program into a dense byte stream.
// Assumes an asynchronous word-read port (data valid in the cycle the address
// is presented) and a downstream sink that may apply backpressure at any time.
module dma_code_packer
    import pk_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              busy,
    output logic              done,
    output logic [CW-1:0]     byte_count,
    output logic              error,
    output logic [7:0]        err_opcode,
    output logic [AW-1:0]     err_addr
);
    op_cls_e            cls;
    logic [LANE_IW-1:0] lane_sel;

    pk_opdecode u_dec (
        .opcode (rd_data[7:0]),
        .cls    (cls)
    );

    pk_lane_mux u_mux (
        .word      (rd_data),
        .sel       (lane_sel),
        .lane_byte (out_byte)
    );

    pk_sequencer #(.AW(AW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .cls        (cls),
        .opcode     (rd_data[7:0]),
        .out_ready  (out_ready),
        .rd_addr    (rd_addr),
        .lane_sel   (lane_sel),
        .out_valid  (out_valid),
        .busy       (busy),
        .done       (done),
        .byte_count (byte_count),
        .error      (error),
        .err_opcode (err_opcode),
        .err_addr   (err_addr)
    );
endmodule

// File: rtl/pk_checker.sv
`timescale 1ns/1ps
// pk_checker: temporal properties of the packer's ports, bound to the top.
module pk_checker #(
    parameter int AW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] rd_addr,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_byte,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] byte_count,
    input logic          error,
    input logic [7:0]    err_opcode
);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));
    // R7
    stall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(rd_addr));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !out_valid);
    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !out_valid);
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error && $stable(err_opcode));
    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && byte_count == '0 && !error);
    // R8
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind dma_code_packer pk_checker #(.AW(AW), .CW(CW)) u_pk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_addr    (rd_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .busy       (busy),
    .done       (done),
    .byte_count (byte_count),
    .error      (error),
    .err_opcode (err_opcode)
);

// File: tb/dma_code_packer_bench.sv
`timescale 1ns/1ps
// dma_code_packer_bench: directed scenarios, each task checks its own results.
module dma_code_packer_bench;
    localparam int AW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_byte;
    logic          busy, done, error;
    logic [CW-1:0] byte_count;
    logic [7:0]    err_opcode;
    logic [AW-1:0] err_addr;

    logic [31:0] mem [0:255];
    assign rd_data = mem[rd_addr];

    always #4 clk = ~clk;

    dma_code_packer #(.AW(AW), .CW(CW)) u_dma_code_packer (.*);

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // ready driving: 0 = always high, 1 = two of three cycles, 2 = held low
    int rdy_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // monitor: capture accepted bytes, count done pulses, watch stalls
    logic [7:0] cap [0:63];
    int cap_n = 0;
    int done_n = 0;
    int stall_viol = 0;
    int stalls = 0;
    logic          pv_stall = 1'b0;
    logic [7:0]    pv_byte;
    logic [AW-1:0] pv_addr;
    always @(negedge clk) begin
        if (pv_stall && !(out_valid && out_byte == pv_byte && rd_addr == pv_addr))
            stall_viol++;
        pv_stall = out_valid && !out_ready;
        if (pv_stall) stalls++;
        pv_byte = out_byte;
        pv_addr = rd_addr;
        if (out_valid && out_ready && cap_n < 64) begin
            cap[cap_n] = out_byte;
            cap_n++;
        end
        if (done) done_n++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [7:0] exp_b [0:63];
    int exp_n;

    task automatic cmp_stream(input string req);
        chk(cap_n == exp_n, {req, " byte total"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            chk(cap[i] == exp_b[i], req, cap[i], exp_b[i]);
    endtask

    task automatic push(input logic [7:0] b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic kick(input logic [AW-1:0] a);
        @(negedge clk);
        cap_n = 0;
        done_n = 0;
        start_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000 && !done && !error; i++) @(negedge clk);
    endtask

    // scenario: reset values
    task automatic t_reset();
        chk(!out_valid && !done && !busy && !error, "R1 flags", {out_valid, done, busy, error}, 0);
        chk(byte_count == 0, "R1 count", byte_count, 0);
    endtask

    // program at word 4 covering every opcode class
    task automatic load_mixed();
        mem[4]  = 32'h5A5A_02BC;  mem[5] = 32'h1122_3344;
        mem[6]  = 32'hAAAA_0F20;
        mem[7]  = 32'hDEAD_BE04;
        mem[8]  = 32'h5555_0108;
        mem[9]  = 32'h1234_5613;
        mem[10] = 32'hFFFF_0334;
        mem[11] = 32'h7777_0238;
        mem[12] = 32'h6666_013C;
        mem[13] = 32'h9999_9922;
        mem[14] = 32'hCAFE_BA00;
        exp_n = 0;
        push(8'hBC); push(8'h02); push(8'h44); push(8'h33); push(8'h22); push(8'h11);
        push(8'h20); push(8'h0F);
        push(8'h04); push(8'h08); push(8'h13);
        push(8'h34); push(8'h03); push(8'h38); push(8'h02); push(8'h3C); push(8'h01);
        push(8'h22); push(8'h99);
        push(8'h00);
    endtask

    // scenario: full program, free-running sink (R2..R5)
    task automatic t_mixed(input int mode, input string tag);
        load_mixed();
        rdy_mode = mode;
        stalls = 0;
        stall_viol = 0;
        kick(8'd4);
        wait_end();
        chk(done, {tag, " R5 done seen"}, done, 1);
        chk(byte_count == 20, {tag, " R5 count at done"}, byte_count, 20);
        chk(!busy, {tag, " R5 idle at done"}, busy, 0);
        @(negedge clk);
        chk(!done && done_n == 1, {tag, " R5 single pulse"}, done_n, 1);
        cmp_stream({tag, " R2 R3 R4 stream"});
        if (mode == 1) begin
            chk(stalls > 0, "R7 stalls occurred", stalls, 1);
            chk(stall_viol == 0, "R7 hold under stall", stall_viol, 0);
        end
        rdy_mode = 0;
    endtask

    // scenario: unknown opcode after one instruction (R6, R9)
    task automatic t_fault();
        mem[40] = 32'h0000_0004;
        mem[41] = 32'h0000_00FF;
        mem[42] = 32'h0000_0000;
        exp_n = 0; push(8'h04);
        rdy_mode = 0;
        kick(8'd40);
        wait_end();
        @(negedge clk);
        chk(error, "R6 error flag", error, 1);
        chk(err_opcode == 8'hFF, "R6 opcode", err_opcode, 8'hFF);
        chk(err_addr == 8'd41, "R6 address", err_addr, 41);
        for (int i = 0; i < 10; i++) @(negedge clk);
        cmp_stream("R6 no bytes after fault");
        chk(error && !busy && done_n == 0, "R6 held", {error, busy}, 2'b10);
        mem[41] = 32'h0000_0013;
        kick(8'd41);
        chk(!error && busy, "R9 restart clears error", {error, busy}, 2'b01);
        wait_end();
        chk(done && byte_count == 2, "R9 restart run", byte_count, 2);
    endtask

    // scenario: start during a stalled run (R8)
    task automatic t_start_busy();
        mem[96]  = 32'h0000_0013; mem[97]  = 32'h0000_0000;
        mem[128] = 32'h0000_0008; mem[129] = 32'h0000_0000;
        rdy_mode = 2;
        kick(8'd96);
        repeat (3) @(negedge clk);
        start_addr = 8'd128;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_addr == 8'd96, "R8 address kept", rd_addr, 96);
        rdy_mode = 0;
        wait_end();
        exp_n = 0; push(8'h13); push(8'h00);
        cmp_stream("R8 first program only");
    endtask

    // scenario: start in the done cycle, then terminator-only program (R9, R5)
    task automatic t_back_to_back();
        mem[150] = 32'h0000_0008; mem[151] = 32'h0000_0000;
        mem[160] = 32'hFFFF_FF00;
        rdy_mode = 0;
        kick(8'd150);
        wait_end();
        chk(done && byte_count == 2, "R5 first run count", byte_count, 2);
        cap_n = 0;
        start_addr = 8'd160;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && byte_count == 0 && !done, "R9 start at done", {busy, done}, 2'b10);
        wait_end();
        chk(done && byte_count == 1, "R5 terminator only count", byte_count, 1);
        exp_n = 0; push(8'h00);
        cmp_stream("R5 terminator only");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed(0, "free");
        t_mixed(1, "stall");
        t_fault();
        t_start_busy();
        t_back_to_back();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule